// File: doc/BRIEF.md
# Dual-Bank Latched Interrupt Controller

This block collects 64 synchronous interrupt request lines into two 32-bit banks and drives one interrupt line toward a processor. Each source is either edge-type, where a rising input latches a sticky event bit that software later clears by writing ones, or level-type, where the current input level is reported directly as pending. Which sources are level-type is fixed by a per-bank trigger map that is constant after reset and cannot be changed from the bus.

Software sees each bank as a small window of 32-bit registers: latched events, an enable mask, the raw sampled input levels, and a write-only clear port. Reads have no side effects and return data combinationally from the addressed register. The interrupt output is registered and is high whenever any bank holds an enabled pending bit.

Top module: `irqc_top`

## Requirements
- R1: After reset, the event, mask and level registers of both banks read zero and `irq_o` is low.
- R2: Source k with k below 32 maps to bank 1 bit k; source k of 32 or above maps to bank 0 bit k-32.
- R3: Bank 0 occupies addresses 0x10 to 0x1F and bank 1 occupies 0x20 to 0x2F; a read anywhere else returns zero and a write anywhere else changes nothing.
- R4: Within a bank, offset 0x0 reads events, offset 0x4 reads and writes the mask, offset 0xC reads levels; offset 0x8 and every other offset read zero, and writes to offsets other than 0x4 and 0x8 change nothing.
- R5: A rising input on an edge-type source sets its event bit at the next clock edge; the bit stays set after the input falls.
- R6: A level-type source never sets its event bit; it is pending exactly while its sampled level is high. Bank 1 bits 20 through 28 are level-type; all others are edge-type.
- R7: A write of value V to offset 0x8 clears each event bit where V has a one; level-type sources stay pending regardless of such writes.
- R8: When a rising edge and a clear write hit the same event bit in the same cycle, the bit ends up set.
- R9: `irq_o` is high exactly when some bank has a bit set in (events OR (levels AND level-type map)) AND mask, and follows a register or input change at the same clock edge that updates the register.
- R10: The level register holds the request inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 64 | Interrupt request lines, synchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Processor interrupt request |

## Verification
A corrupted event, mask or level bit shows up on `rdata_o` as soon as the bank is read, and on `irq_o` at the same clock edge whenever that bit is enabled. A wrong trigger-map bit appears as an event reading one on a level source, or as an interrupt that persists after the input drops. A decode fault shows up as a nonzero read from an unmapped address or a mask that changed after a write elsewhere.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BANK_W    = 32;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned NUM_SRC   = BANK_W * NUM_BANKS;

  // Register selector within a bank window.
  typedef enum logic [2:0] {
    RSEL_EVENT,
    RSEL_MASK,
    RSEL_CLEAR,
    RSEL_LEVEL,
    RSEL_NONE
  } rsel_e;

  localparam logic [3:0] OFS_EVENT = 4'h0;
  localparam logic [3:0] OFS_MASK  = 4'h4;
  localparam logic [3:0] OFS_CLEAR = 4'h8;
  localparam logic [3:0] OFS_LEVEL = 4'hC;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BASE   = 'h10
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] bank_sel_o,
  output rsel_e                rsel_o
);
  logic [ADDR_W-1:0] rel;

  always_comb begin
    rel = addr_i - ADDR_W'(BASE);
  end

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_sel
      assign bank_sel_o[b] = (rel[ADDR_W-1:4] == (ADDR_W-4)'(b));
    end
  endgenerate

  always_comb begin
    unique case (addr_i[3:0])
      OFS_EVENT: rsel_o = RSEL_EVENT;
      OFS_MASK:  rsel_o = RSEL_MASK;
      OFS_CLEAR: rsel_o = RSEL_CLEAR;
      OFS_LEVEL: rsel_o = RSEL_LEVEL;
      default:   rsel_o = RSEL_NONE;
    endcase
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter logic [BANK_W-1:0] LVL_MAP = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] req_i,
  input  logic              mask_we_i,
  input  logic              clr_we_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] event_o,
  output logic [BANK_W-1:0] mask_o,
  output logic [BANK_W-1:0] level_o,
  output logic              pend_next_o
);
  logic [BANK_W-1:0] event_q, event_d;
  logic [BANK_W-1:0] mask_q,  mask_d;
  logic [BANK_W-1:0] level_q, level_d;
  logic [BANK_W-1:0] rise, clr_bits;

  // Next-state logic.
  always_comb begin
    rise     = req_i & ~level_q & ~LVL_MAP;
    clr_bits = clr_we_i ? (wdata_i & ~LVL_MAP) : '0;
    event_d  = (event_q & ~clr_bits) | rise;   // set beats clear
    mask_d   = mask_we_i ? wdata_i : mask_q;
    level_d  = req_i;
    pend_next_o = |((event_d | (level_d & LVL_MAP)) & mask_d);
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      event_q <= '0;
      level_q <= '0;
    end else begin
      event_q <= event_d;
      level_q <= level_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= mask_d;
    end
  end

  assign event_o = event_q;
  assign mask_o  = mask_q;
  assign level_o = level_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned       ADDR_W = 12,
  parameter logic [BANK_W-1:0] LVL_MAP_B0 = 32'h0000_0000,
  parameter logic [BANK_W-1:0] LVL_MAP_B1 = 32'h1FF0_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BANK_W-1:0]  wdata_i,
  output logic [BANK_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic [NUM_BANKS-1:0] bank_sel;
  rsel_e                rsel;
  logic [BANK_W-1:0]    ev   [NUM_BANKS];
  logic [BANK_W-1:0]    mk   [NUM_BANKS];
  logic [BANK_W-1:0]    lv   [NUM_BANKS];
  logic [NUM_BANKS-1:0] pend_next;
  logic                 irq_d;
  logic                 irq_q;

  irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (addr_i),
    .bank_sel_o(bank_sel),
    .rsel_o    (rsel)
  );

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      // Sources are assigned to banks in reverse order.
      localparam int unsigned SRC_LO = (NUM_BANKS - 1 - b) * BANK_W;
      localparam logic [BANK_W-1:0] MAP = (b == 0) ? LVL_MAP_B0 : LVL_MAP_B1;
      irqc_bank #(.LVL_MAP(MAP)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i[SRC_LO +: BANK_W]),
        .mask_we_i  (wr_en_i && bank_sel[b] && (rsel == RSEL_MASK)),
        .clr_we_i   (wr_en_i && bank_sel[b] && (rsel == RSEL_CLEAR)),
        .wdata_i    (wdata_i),
        .event_o    (ev[b]),
        .mask_o     (mk[b]),
        .level_o    (lv[b]),
        .pend_next_o(pend_next[b])
      );
    end
  endgenerate

  // Read mux.
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (bank_sel[i]) begin
        unique case (rsel)
          RSEL_EVENT: rdata_o = ev[i];
          RSEL_MASK:  rdata_o = mk[i];
          RSEL_LEVEL: rdata_o = lv[i];
          default:    rdata_o = '0;
        endcase
      end
    end
  end

  always_comb begin
    irq_d = |pend_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int unsigned       ADDR_W = 12,
  parameter logic [BANK_W-1:0] MAP1   = 32'h1FF0_0000
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] req_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [BANK_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [BANK_W-1:0]  ev0, ev1, mk0, mk1, lv0, lv1
);
  logic addr_bad;
  always_comb addr_bad = (addr_i[ADDR_W-1:4] != 'h1) && (addr_i[ADDR_W-1:4] != 'h2);

  // R9: output equals the OR of both banks' enabled pending bits.
  p_irq_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(ev0 & mk0) || |((ev1 | (lv1 & MAP1)) & mk1)));

  // R10: level register is the previous input sample.
  p_level_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lv0 == $past(req_i[63:32])) && (lv1 == $past(req_i[31:0])));

  // R6: level-type sources never hold an event.
  p_level_no_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev1 & MAP1) == '0);

  // R5: a rising edge on bank 0 sets the matching event bits.
  p_edge_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_i[63:32] & ~lv0) != '0) |=>
      ((ev0 & $past(req_i[63:32] & ~lv0)) == $past(req_i[63:32] & ~lv0)));

  // R3: unmapped addresses read zero.
  p_bad_addr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_bad |-> (rdata_o == '0));
endmodule

bind irqc_top irqc_checker #(.ADDR_W(ADDR_W), .MAP1(LVL_MAP_B1)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req_i  (req_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .ev0    (ev[0]),
  .ev1    (ev[1]),
  .mk0    (mk[0]),
  .mk1    (mk[1]),
  .lv0    (lv[0]),
  .lv1    (lv[1])
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int CLK_P = 10;
  localparam int NV = 8;
  // Entry: {source[6:0], bank[0], bit[4:0], level_type[0]}
  localparam logic [13:0] VEC [NV] = '{
    {7'd0,  1'b1, 5'd0,  1'b0},
    {7'd5,  1'b1, 5'd5,  1'b0},
    {7'd20, 1'b1, 5'd20, 1'b1},
    {7'd28, 1'b1, 5'd28, 1'b1},
    {7'd29, 1'b1, 5'd29, 1'b0},
    {7'd31, 1'b1, 5'd31, 1'b0},
    {7'd32, 1'b0, 5'd0,  1'b0},
    {7'd63, 1'b0, 5'd31, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] req;
  logic        wr_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic clear_all();
    req = '0;
    @(negedge clk);
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h028, 32'hFFFF_FFFF);
    wr(12'h014, 32'h0);
    wr(12'h024, 32'h0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; req = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(12'h010, d); chk("R1 ev0", d, 0);
    rd(12'h014, d); chk("R1 mk0", d, 0);
    rd(12'h01C, d); chk("R1 lv0", d, 0);
    rd(12'h020, d); chk("R1 ev1", d, 0);
    rd(12'h024, d); chk("R1 mk1", d, 0);
    rd(12'h02C, d); chk("R1 lv1", d, 0);
    chk("R1 irq", 32'(irq), 0);

    // Table walk: R2 R5 R6 R7 R9 R10
    for (int i = 0; i < NV; i++) begin
      logic [6:0]  k;
      logic [11:0] base;
      logic [31:0] bm;
      logic        lvl;
      k    = VEC[i][13:7];
      base = VEC[i][6] ? 12'h020 : 12'h010;
      bm   = 32'h1 << VEC[i][5:1];
      lvl  = VEC[i][0];
      clear_all();
      @(negedge clk); req[k] = 1'b1;
      @(negedge clk);
      rd(base + 12'hC, d); chk($sformatf("R2 R10 level src%0d", k), d, bm);
      rd(base, d); chk($sformatf("R5 R6 event src%0d", k), d, lvl ? 32'h0 : bm);
      chk($sformatf("R9 masked src%0d", k), 32'(irq), 0);
      wr(base + 12'h4, bm);
      chk($sformatf("R9 enabled src%0d", k), 32'(irq), 1);
      @(negedge clk); req[k] = 1'b0;
      @(negedge clk);
      chk($sformatf("R5 R6 after fall src%0d", k), 32'(irq), lvl ? 0 : 1);
      wr(base + 12'h8, bm);
      chk($sformatf("R7 cleared src%0d", k), 32'(irq), 0);
    end

    // R4: mask readback and odd offsets
    clear_all();
    wr(12'h014, 32'hA5A5_0000);
    rd(12'h014, d); chk("R4 mask rw", d, 32'hA5A5_0000);
    rd(12'h018, d); chk("R4 clear reads zero", d, 0);
    rd(12'h015, d); chk("R4 odd offset zero", d, 0);
    wr(12'h015, 32'h0000_FFFF);
    rd(12'h014, d); chk("R4 odd write ignored", d, 32'hA5A5_0000);

    // R3: unmapped addresses
    wr(12'h034, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'hFF4, 32'hFFFF_FFFF);
    rd(12'h014, d); chk("R3 mk0 untouched", d, 32'hA5A5_0000);
    rd(12'h024, d); chk("R3 mk1 untouched", d, 0);
    req[40] = 1'b1;
    @(negedge clk);
    rd(12'h03C, d); chk("R3 unmapped read", d, 0);
    rd(12'h00C, d); chk("R3 low unmapped read", d, 0);

    // R8: set wins over simultaneous clear
    clear_all();
    @(negedge clk);
    req[33] = 1'b1; addr = 12'h018; wdata = 32'h2; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd(12'h010, d); chk("R8 set wins", d, 32'h2);
    wr(12'h018, 32'h2);
    rd(12'h010, d); chk("R7 edge clear held input", d, 0);

    // R7: clear cannot affect a level source
    clear_all();
    @(negedge clk); req[20] = 1'b1;
    wr(12'h024, 32'h0010_0000);
    wr(12'h028, 32'h0010_0000);
    chk("R7 level survives clear", 32'(irq), 1);
    rd(12'h020, d); chk("R6 no level event", d, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule